// File: doc/BRIEF.md
# Pin Level-Change Detector with Gated Interrupt

This block watches a single input pin that is asynchronous to the system clock and reports any change of its level. The pin first passes through a multi-stage synchroniser. The block then compares each synchronised sample with a copy of the sample taken one cycle earlier. When the two differ, in either direction, it sets a sticky status flag.

The status flag is independent of the interrupt enable. The enable only decides whether a set flag drives the interrupt output. Software clears the flag with a single-cycle write-one pulse on the clear input. If a new change arrives in the same cycle as the clear, the change wins.

After reset, the comparison is held off until the synchroniser has filled and the stored copy holds a real sample. This way the pin level present at reset is never reported as a change.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the status flag, the interrupt and the synchronised level output are all 0.
- R2: The synchronised level output shows the pin value that was sampled SYNC_STAGES clock edges earlier (2 edges by default).
- R3: A 0-to-1 transition of the synchronised level sets the status flag on the following clock edge.
- R4: A 1-to-0 transition of the synchronised level sets the status flag on the following clock edge.
- R5: The status flag is set by a change even while the interrupt enable is 0.
- R6: The interrupt output is 1 exactly when the enable input is 1 and the status flag is 1. The enable changes the interrupt in the same cycle, without any delay.
- R7: A 1 on the clear input in a cycle with no detected change drives the status flag to 0 on the next edge.
- R8: When a change is detected in the same cycle as the clear pulse, the status flag is 1 after that edge.
- R9: Once set, the status flag stays at 1 until a clear pulse, even if the pin becomes stable again.
- R10: A pin held at 1 through and after reset does not set the status flag. No change is flagged before SYNC_STAGES+1 clock edges have passed since reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_async | input | 1 | Raw pin, asynchronous to clk |
| irq_en | input | 1 | Interrupt enable; gates only the interrupt output |
| clr_pulse | input | 1 | Write-one clear of the status flag |
| chg_status | output | 1 | Sticky level-change flag |
| chg_irq | output | 1 | Interrupt request |
| pin_level | output | 1 | Synchronised pin level |

## Verification
The stimulus includes the following patterns:
- A pin held high across reset, which separates a correctly armed comparator from one that reports the reset value of the synchroniser as a change.
- Rising and falling steps, applied with the enable both low and high, which show that direction and enable have no effect on the flag but do gate the interrupt.
- A clear on a stable pin, contrasted with a clear timed into the exact cycle in which a change is seen, which separates plain clearing from the rule that a change wins.
- A two-cycle glitch, followed by a long quiet stretch, which confirms that short pulses are caught and that the flag stays sticky.

// File: rtl/pcd_pkg.sv
// Package: shared constants and helpers for the pin change detector.
// Assumes: stage counts are small positive integers.
package pcd_pkg;

    // Smallest synchroniser depth accepted by the block.
    localparam int unsigned PCD_MIN_STAGES = 2;

    // Edges after reset before the stored copy holds a real synchronised sample.
    function automatic int unsigned pcd_arm_edges(input int unsigned stages);
        return stages + 1;
    endfunction

    // Width needed to count up to a given value inclusive.
    function automatic int unsigned pcd_cnt_width(input int unsigned maxval);
        int unsigned w;
        w = 1;
        while ((1 << w) <= maxval) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/pcd_sync.sv
// Module: pcd_sync
// What: N-stage flop chain that brings an asynchronous bit into the clk domain.
// Assumes: STAGES >= 2; all stages reset to 0 on synchronous active-low reset.
module pcd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the raw bit through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pcd_edge_track.sv
// Module: pcd_edge_track
// What: keeps the previous synchronised sample and flags any difference from
//       the current one, in both directions, once the pipeline is armed.
// Assumes: level_in comes from a synchroniser of depth SYNC_STAGES that
//          resets to 0.
module pcd_edge_track
    import pcd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic change_seen
);

    localparam int unsigned ARM_EDGES = pcd_arm_edges(SYNC_STAGES);
    localparam int unsigned CNT_W     = pcd_cnt_width(ARM_EDGES);
    localparam logic [CNT_W-1:0] ARM_LIMIT = CNT_W'(ARM_EDGES);

    logic [CNT_W-1:0] arm_cnt_q;
    logic             armed;
    logic             prev_q;

    assign armed = (arm_cnt_q == ARM_LIMIT);

    // Purpose: count edges after reset until the stored copy is trustworthy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_cnt_q <= '0;
        end else if (!armed) begin
            arm_cnt_q <= arm_cnt_q + 1'b1;
        end
    end

    // Purpose: remember the synchronised level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_in;
        end
    end

    // Purpose: report a level difference in either direction once armed.
    always_comb begin
        change_seen = armed && (level_in ^ prev_q);
    end

endmodule

// File: rtl/pcd_status.sv
// Module: pcd_status
// What: sticky change flag with write-one clear; a detected change overrides
//       a clear in the same cycle. Also forms the enable-gated interrupt.
// Assumes: clr_in is a single-cycle pulse; irq_en_in may change at any cycle.
module pcd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic change_in,
    input  logic clr_in,
    input  logic irq_en_in,
    output logic status_out,
    output logic irq_out
);

    logic status_q;

    // Purpose: set on change, hold otherwise, drop on clear unless a change arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= change_in | (status_q & ~clr_in);
        end
    end

    // Purpose: gate the interrupt with the enable; the flag itself is never gated.
    always_comb begin
        irq_out = irq_en_in & status_q;
    end

    assign status_out = status_q;

endmodule

// File: rtl/pin_change_irq.sv
// Module: pin_change_irq (top)
// What: synchronises an asynchronous pin, detects any level change, keeps a
//       sticky flag and raises an interrupt when enabled.
// Assumes: clk is free running; rst_n is synchronous, active low.
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic irq_en,
    input  logic clr_pulse,
    output logic chg_status,
    output logic chg_irq,
    output logic pin_level
);

    localparam int unsigned STAGES_USED =
        (SYNC_STAGES < PCD_MIN_STAGES) ? PCD_MIN_STAGES : SYNC_STAGES;

    logic level_sync;
    logic change_seen;

    pcd_sync #(
        .STAGES (STAGES_USED)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (level_sync)
    );

    pcd_edge_track #(
        .SYNC_STAGES (STAGES_USED)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_in    (level_sync),
        .change_seen (change_seen)
    );

    pcd_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .change_in  (change_seen),
        .clr_in     (clr_pulse),
        .irq_en_in  (irq_en),
        .status_out (chg_status),
        .irq_out    (chg_irq)
    );

    assign pin_level = level_sync;

endmodule

// File: rtl/pcd_checker.sv
// Module: pcd_checker
// What: port-level temporal checks for pin_change_irq, attached by bind.
// Assumes: same SYNC_STAGES as the bound instance (>= 2).
module pcd_checker #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic irq_en,
    input logic clr_pulse,
    input logic chg_status,
    input logic chg_irq,
    input logic pin_level
);

    localparam int unsigned ARM = SYNC_STAGES + 1;

    int unsigned edges_q;
    logic        armed_chk;

    // Purpose: count edges since reset release, saturating at the arm point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= 0;
        end else if (edges_q < ARM) begin
            edges_q <= edges_q + 1;
        end
    end

    assign armed_chk = (edges_q >= ARM);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!chg_status && !pin_level));

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> (irq_en && chg_status));

    assert_irq_follows_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && chg_status) |-> chg_irq);

    assert_change_sets_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_chk && (pin_level != $past(pin_level))) |=> chg_status);

    assert_change_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_chk && clr_pulse && (pin_level != $past(pin_level))) |=> chg_status);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && (pin_level == $past(pin_level))) |=> !chg_status);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_status && !clr_pulse) |=> chg_status);

    assert_no_early_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_chk |=> !chg_status);

endmodule

bind pin_change_irq pcd_checker #(
    .SYNC_STAGES (STAGES_USED)
) u_pcd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .clr_pulse  (clr_pulse),
    .chg_status (chg_status),
    .chg_irq    (chg_irq),
    .pin_level  (pin_level)
);

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_async = 1'b0;
    logic irq_en = 1'b0;
    logic clr_pulse = 1'b0;
    logic chg_status;
    logic chg_irq;
    logic pin_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R1";

    // Behavioural model state
    bit hist[$];
    int m_edges = 0;
    bit m_status = 1'b0;
    bit m_level = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pin_change_irq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (pin_async),
        .irq_en     (irq_en),
        .clr_pulse  (clr_pulse),
        .chg_status (chg_status),
        .chg_irq    (chg_irq),
        .pin_level  (pin_level)
    );

    // Reference model: pins sampled per edge, level lags two edges,
    // change armed from the fourth edge after reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_edges = 0;
            m_status = 1'b0;
            m_level = 1'b0;
        end else begin
            bit chg;
            m_edges++;
            hist.push_back(pin_async);
            if (hist.size() > 4) void'(hist.pop_front());
            chg = (m_edges >= 4) && (hist[hist.size()-3] != hist[hist.size()-4]);
            m_status = chg || (m_status && !clr_pulse);
            m_level = (m_edges >= 2) ? hist[hist.size()-2] : 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(phase, "status", chg_status, m_status);
            chk("R6", "irq", chg_irq, irq_en && m_status);
            chk("R2", "level", pin_level, m_level);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1 and R10: reset with the pin held high
        pin_async = 1'b1;
        cyc(4);
        chk("R1", "status in reset", chg_status, 1'b0);
        chk("R1", "irq in reset", chg_irq, 1'b0);
        chk("R1", "level in reset", pin_level, 1'b0);
        rst_n = 1'b1;
        phase = "R10";
        cyc(10);
        chk("R10", "no false flag", chg_status, 1'b0);
        chk("R2", "level high", pin_level, 1'b1);

        // R4 and R5: falling change with enable low
        phase = "R4";
        pin_async = 1'b0;
        cyc(1);
        chk("R2", "level lags", pin_level, 1'b1);
        cyc(1);
        chk("R2", "level after two edges", pin_level, 1'b0);
        chk("R4", "not yet set", chg_status, 1'b0);
        cyc(1);
        chk("R5", "set with enable low", chg_status, 1'b1);
        chk("R6", "irq gated off", chg_irq, 1'b0);

        // R6: enabling shows the interrupt at once
        phase = "R6";
        irq_en = 1'b1;
        #1;
        chk("R6", "irq on enable", chg_irq, 1'b1);

        // R9: sticky
        phase = "R9";
        cyc(20);
        chk("R9", "still set", chg_status, 1'b1);

        // R7: clear on a quiet pin
        phase = "R7";
        clr_pulse = 1'b1;
        cyc(1);
        clr_pulse = 1'b0;
        chk("R7", "cleared", chg_status, 1'b0);
        chk("R7", "irq cleared", chg_irq, 1'b0);

        // R3: rising change
        phase = "R3";
        pin_async = 1'b1;
        cyc(3);
        chk("R3", "rise sets", chg_status, 1'b1);
        chk("R6", "irq on rise", chg_irq, 1'b1);
        clr_pulse = 1'b1;
        cyc(1);
        clr_pulse = 1'b0;
        cyc(2);
        chk("R7", "cleared again", chg_status, 1'b0);

        // R8: clear in the very cycle the change is seen
        phase = "R8";
        pin_async = 1'b0;
        cyc(2);             // level just flipped: change seen this cycle
        clr_pulse = 1'b1;
        cyc(1);
        clr_pulse = 1'b0;
        chk("R8", "change beats clear", chg_status, 1'b1);

        // R3: short glitch is caught, then stays sticky
        clr_pulse = 1'b1;
        cyc(1);
        clr_pulse = 1'b0;
        irq_en = 1'b0;
        phase = "R3";
        pin_async = 1'b1;
        cyc(2);
        pin_async = 1'b0;
        cyc(15);
        chk("R3", "glitch caught", chg_status, 1'b1);
        chk("R6", "irq gated", chg_irq, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule